// File: doc/BRIEF.md
# Step attenuator control front end

This block is the digital control side of a 5-bit step attenuator. It produces a registered attenuation code. Bits 4 down to 0 of the code carry weights of 8, 4, 2, 1 and 0.5 dB, so the code spans 32 states. All zeros is reference loss and all ones is 15.5 dB. The code can come from two sources. One is five parallel control pins. The other is a 6-bit shift register, loaded through a serial data pin and a serial clock pin. A mode pin picks the source. Both sources feed one shared latch. While the latch-enable pin is high, the latch is transparent; while it is low, the latch holds its value.

All pins are asynchronous to the system clock. Each one passes through a synchronizer of `SYNC_STAGES` flops before it is used. A pin change therefore reaches `code_o` `SYNC_STAGES`+1 system clock cycles later. When reset is released, the block waits until its synchronizers are filled. It then applies a one-time power-up rule, which depends on the mode pin, the latch-enable pin and a power-up select pin.

Top module: `att_ctrl`

## Requirements
- R1: While `rst_ni` is low, `code_o` is 00000 and `start_err_o` is 0.
- R2: On the first power-up update after reset, with `ser_mode_i`=1, `code_o` takes the value on `ctrl_i`.
- R3: On the power-up update, with `ser_mode_i`=0 and `le_i`=0, `code_o` becomes 00000 if `pup_sel_i`=0 and 10000 if `pup_sel_i`=1.
- R4: On the power-up update, with `ser_mode_i`=0 and `le_i`=1, `code_o` takes `ctrl_i`. `pup_sel_i` has no effect, either then or afterwards.
- R5: `ser_mode_i`=0 selects `ctrl_i` as the source and `ser_mode_i`=1 selects the shift register. In serial mode, changes on `ctrl_i` do not reach `code_o`.
- R6: Each rising edge of `sclk_i` shifts `sdata_i` into bit 0 of a 6-bit register, so the first bit sent ends up in bit 5 (MSB first). Shifting happens whatever the level of `le_i`. Bit 5 is the start bit. Bits 4..0 drive `code_o[4:0]`, with weights 8, 4, 2, 1 and 0.5 dB.
- R7: While `le_i`=1, `code_o` follows the selected source `SYNC_STAGES`+1 cycles after a change. A high pulse on `le_i` captures the source value as it was when the pulse ended.
- R8: While `le_i`=0, `code_o` holds its value, whatever `ctrl_i`, `sdata_i`, `sclk_i` or `pup_sel_i` do.
- R9: In serial mode with `le_i`=1, a start bit of 1 keeps `code_o` at its previous value and sets `start_err_o` to 1. `start_err_o` clears the next time the latch is open on a source whose start bit is 0, or on the parallel source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| ser_mode_i | input | 1 | 1 selects the serial source, 0 selects the parallel source |
| le_i | input | 1 | Latch enable: 1 makes the latch transparent, 0 holds it |
| sclk_i | input | 1 | Serial shift clock, sampled on its rising edge |
| sdata_i | input | 1 | Serial data, MSB first |
| ctrl_i | input | 5 | Parallel control pins, bit 4 = 8 dB down to bit 0 = 0.5 dB |
| pup_sel_i | input | 1 | Power-up select for parallel mode with the latch closed |
| code_o | output | 5 | Latched attenuation code |
| start_err_o | output | 1 | Set when the latch met a serial word with its start bit high |

## Verification
The hardest situations to reach are the power-up rules, because each one exists only in the single update that follows a reset. The stimulus therefore reset-cycles the block four times, with a different mode, latch-enable and select combination held steady across each release. Reaching the start-bit fault needs a whole serial word with bit 5 set, shifted in while the latch is closed and then exposed by a latch pulse. Clearing it needs a valid word and a second pulse. A word is also shifted with the latch held open, to show that the intermediate shift states settle on the final word.

// File: rtl/att_ctrl_pkg.sv
package att_ctrl_pkg;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned WORD_W = CODE_W + 1;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [WORD_W-1:0] word_t;

  // parallel, latch closed, select high -> 8 dB step only
  localparam code_t PUP_HI_CODE = code_t'(1) << (CODE_W - 1);
  localparam code_t PUP_LO_CODE = '0;

  function automatic code_t pup_code(input logic  ser_mode,
                                     input logic  le,
                                     input logic  sel,
                                     input code_t pins);
    code_t res;
    if (ser_mode || le) res = pins;
    else if (sel)       res = PUP_HI_CODE;
    else                res = PUP_LO_CODE;
    return res;
  endfunction
endpackage

// File: rtl/att_sync.sv
module att_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/att_shift.sv
module att_shift
  import att_ctrl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sclk_i,
  input  logic  sdata_i,
  output word_t word_o,
  output logic  shift_o
);
  logic  sclk_d_q;
  word_t sr_q;

  assign shift_o = sclk_i & ~sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      sr_q     <= '0;
    end else begin
      sclk_d_q <= sclk_i;
      // shifting is independent of latch enable
      if (shift_o) sr_q <= {sr_q[WORD_W-2:0], sdata_i};
    end
  end

  assign word_o = sr_q;
endmodule

// File: rtl/att_latch.sv
module att_latch
  import att_ctrl_pkg::*;
#(
  parameter int unsigned INIT_CYC = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ser_mode_i,
  input  logic  le_i,
  input  logic  pup_sel_i,
  input  code_t pins_i,
  input  word_t word_i,
  output code_t code_o,
  output logic  err_o,
  output logic  init_o,
  output logic  apply_o
);
  localparam int unsigned CNT_W = $clog2(INIT_CYC + 1) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             init_q;
  code_t            code_q;
  logic             err_q;
  code_t            src;
  logic             start_bad;

  assign apply_o   = init_q && (cnt_q == CNT_W'(INIT_CYC));
  assign src       = ser_mode_i ? word_i[CODE_W-1:0] : pins_i;
  assign start_bad = ser_mode_i & word_i[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      init_q <= 1'b1;
    end else if (init_q) begin
      if (apply_o) init_q <= 1'b0;
      else         cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      err_q  <= 1'b0;
    end else if (init_q) begin
      if (apply_o) code_q <= pup_code(ser_mode_i, le_i, pup_sel_i, pins_i);
    end else if (le_i) begin
      if (start_bad) begin
        err_q <= 1'b1;
      end else begin
        code_q <= src;
        err_q  <= 1'b0;
      end
    end
  end

  assign code_o = code_q;
  assign err_o  = err_q;
  assign init_o = init_q;
endmodule

// File: rtl/att_ctrl.sv
module att_ctrl
  import att_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_mode_i,
  input  logic              le_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic [CODE_W-1:0] ctrl_i,
  input  logic              pup_sel_i,
  output logic [CODE_W-1:0] code_o,
  output logic              start_err_o
);
  localparam int unsigned IN_W = CODE_W + 5;

  logic [IN_W-1:0] raw, syn;
  logic  mode_s, le_s, sclk_s, sdata_s, pup_s;
  code_t pins_s;
  word_t word;
  logic  shift;
  logic  init_q, apply;

  assign raw = {ser_mode_i, le_i, sclk_i, sdata_i, pup_sel_i, ctrl_i};

  att_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {mode_s, le_s, sclk_s, sdata_s, pup_s, pins_s} = syn;

  att_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_s),
    .sdata_i(sdata_s),
    .word_o (word),
    .shift_o(shift)
  );

  att_latch #(.INIT_CYC(SYNC_STAGES)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_mode_i(mode_s),
    .le_i      (le_s),
    .pup_sel_i (pup_s),
    .pins_i    (pins_s),
    .word_i    (word),
    .code_o    (code_o),
    .err_o     (start_err_o),
    .init_o    (init_q),
    .apply_o   (apply)
  );
endmodule

// File: rtl/att_ctrl_chk.sv
module att_ctrl_chk
  import att_ctrl_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  mode_s,
  input logic  le_s,
  input logic  pup_s,
  input code_t pins_s,
  input word_t word,
  input logic  shift,
  input logic  init_q,
  input logic  apply,
  input code_t code_o,
  input logic  start_err_o
);
  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (code_o == '0 && !start_err_o));

  a_r3_pup_parallel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && !mode_s && !le_s) |=>
      code_o == ($past(pup_s) ? PUP_HI_CODE : PUP_LO_CODE));

  a_r6_shift_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift |=> word[WORD_W-1:1] == $past(word[WORD_W-2:0]));

  a_r7_parallel_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_q && le_s && !mode_s) |=> (code_o == $past(pins_s) && !start_err_o));

  a_r8_closed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_q && !le_s) |=> $stable(code_o));

  a_r9_start_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_q && le_s && mode_s && word[WORD_W-1]) |=> ($stable(code_o) && start_err_o));
endmodule

bind att_ctrl att_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_s     (mode_s),
  .le_s       (le_s),
  .pup_s      (pup_s),
  .pins_s     (pins_s),
  .word       (word),
  .shift      (shift),
  .init_q     (init_q),
  .apply      (apply),
  .code_o     (code_o),
  .start_err_o(start_err_o)
);

// File: tb/att_ctrl_tb.sv
`timescale 1ns/1ps
module att_ctrl_tb;
  localparam int SETTLE = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser_mode = 1'b0, le = 1'b0, sclk = 1'b0, sdata = 1'b0, pup_sel = 1'b0;
  logic [4:0] ctrl = '0;
  logic [4:0] code;
  logic       err;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] code;
    logic       err;
    string      req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  att_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_mode_i(ser_mode), .le_i(le),
    .sclk_i(sclk), .sdata_i(sdata), .ctrl_i(ctrl), .pup_sel_i(pup_sel),
    .code_o(code), .start_err_o(err)
  );

  // monitor: compare queued expectations against the outputs
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (code !== e.code || err !== e.err) begin
        n_fail++;
        $display("FAIL %s: code=%b err=%b expected code=%b err=%b",
                 e.req, code, err, e.code, e.err);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input logic [4:0] c, input logic e, input string r);
    exp_t x;
    x.code = c; x.err = e; x.req = r;
    q.push_back(x);
    wait_clk(2);
  endtask

  task automatic expect_settled(input logic [4:0] c, input logic e, input string r);
    wait_clk(SETTLE);
    expect_now(c, e, r);
  endtask

  task automatic power_up(input logic m, input logic l, input logic p, input logic [4:0] pins);
    @(negedge clk);
    rst_ni = 1'b0;
    ser_mode = m; le = l; pup_sel = p; ctrl = pins; sclk = 1'b0; sdata = 1'b0;
    wait_clk(3);
    expect_now(5'b00000, 1'b0, "R1 reset state");
    rst_ni = 1'b1;
  endtask

  task automatic pulse_le();
    le = 1'b1;
    wait_clk(SETTLE);
    le = 1'b0;
    wait_clk(SETTLE);
  endtask

  task automatic shift_word(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) begin
      sdata = w[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
    end
  endtask

  initial begin
    wait_clk(2);
    // R3: parallel, latch closed, select low / high
    power_up(1'b0, 1'b0, 1'b0, 5'b10101);
    expect_settled(5'b00000, 1'b0, "R3 pup select low");
    ctrl = 5'b01111;
    expect_settled(5'b00000, 1'b0, "R8 pins ignored while closed");
    pup_sel = 1'b1;
    expect_settled(5'b00000, 1'b0, "R8 select ignored while closed");

    power_up(1'b0, 1'b0, 1'b1, 5'b00011);
    expect_settled(5'b10000, 1'b0, "R3 pup select high");

    // R4: parallel, latch open: select has no effect
    power_up(1'b0, 1'b1, 1'b1, 5'b00110);
    expect_settled(5'b00110, 1'b0, "R4 pup latch open");
    pup_sel = 1'b0;
    expect_settled(5'b00110, 1'b0, "R4 select no effect");
    ctrl = 5'b11111;
    expect_settled(5'b11111, 1'b0, "R7 direct follow 15.5dB");
    ctrl = 5'b00001;
    expect_settled(5'b00001, 1'b0, "R5 parallel source");
    le = 1'b0;
    wait_clk(SETTLE);
    ctrl = 5'b01010;
    expect_settled(5'b00001, 1'b0, "R8 hold while closed");
    pulse_le();
    expect_settled(5'b01010, 1'b0, "R7 pulse captures pins");
    ctrl = 5'b10100;
    expect_settled(5'b01010, 1'b0, "R8 hold after pulse");

    // R2: serial power-up takes pins
    power_up(1'b1, 1'b0, 1'b0, 5'b11011);
    expect_settled(5'b11011, 1'b0, "R2 serial pup from pins");
    shift_word(6'b010000);
    expect_settled(5'b11011, 1'b0, "R8 shift while closed no output change");
    pulse_le();
    expect_settled(5'b10000, 1'b0, "R6 msb first word 8dB");
    le = 1'b1;
    ctrl = 5'b00000;
    expect_settled(5'b10000, 1'b0, "R5 pins ignored in serial mode");
    le = 1'b0;
    wait_clk(SETTLE);

    // R9: start bit set
    shift_word(6'b100011);
    pulse_le();
    expect_settled(5'b10000, 1'b1, "R9 start bit held and flagged");
    shift_word(6'b000001);
    pulse_le();
    expect_settled(5'b00001, 1'b0, "R9 flag cleared by valid word");

    // R6: shifting with latch open
    le = 1'b1;
    wait_clk(SETTLE);
    shift_word(6'b001100);
    expect_settled(5'b01100, 1'b0, "R6 shift with latch open");
    le = 1'b0;
    wait_clk(SETTLE);

    // R5: back to parallel source
    ctrl = 5'b00111;
    ser_mode = 1'b0;
    wait_clk(SETTLE);
    expect_now(5'b01100, 1'b0, "R5 mode change while closed holds");
    pulse_le();
    expect_settled(5'b00111, 1'b0, "R5 parallel source after mode change");

    wait_clk(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule